// File: doc/BRIEF.md
# Motion PWM Generator with Dead-Band

This block is one channel pair of a motion-control pulse-width modulator. A 16-bit counter runs either as a down-counter that reloads from a programmable period value, or as a triangle counter that climbs from zero to the period value and falls back. The counter raises events when it sits at zero, when it equals the period value and when it equals either of two compare values. Two internal PWM signals are built by applying a 2-bit action to each of these events, so any edge placement within a period can be programmed.

The period and compare values can be written for immediate use or held in shadow registers and applied together when the counter is at zero, which keeps a running waveform glitch-free. A dead-band stage can turn the first PWM signal into a complementary pair for a half-bridge, delaying the rising edge of each side by its own count, or it can be bypassed. A final output stage gives each output an enable, a polarity inversion and a fault-forcing option driven by a fault input.

Top module: `mcpwm_gen`

## Requirements
- R1: While rst_n is low, cnt_out is 0 and, with out_inv = 0 and db_en = 0, pwm_out is 0; both internal PWM signals start low.
- R2: With updown_mode = 0 the count decrements by one per cycle; at 0 it reloads with the period value in effect after that edge, giving a period of P+1 cycles.
- R3: With updown_mode = 1 the count rises by one per cycle until it reaches the period value P, then falls by one per cycle to 0 and rises again, giving a period of 2P cycles; the direction is up after reset.
- R4: With sync_upd = 0 a write strobe (load_wr, cmpa_wr, cmpb_wr) makes the new period or compare value active from the next cycle, and the count steps against the new period at that edge.
- R5: With sync_upd = 1 written values are held back and all three become active at the clock edge where the count is 0; a write arriving on that very cycle takes effect at that edge.
- R6: Each internal PWM signal has an 8-bit action field (act_a, act_b): bits 1:0 act on count = 0, bits 3:2 on count = period value, bits 5:4 on count = compare A, bits 7:6 on count = compare B; codes are 00 keep, 01 toggle, 10 drive low, 11 drive high, applied at the next clock edge.
- R7: When several events occur on one cycle, only the action of the highest-priority event with a non-00 code is applied; priority from high to low is compare B, compare A, period, zero.
- R8: With db_en = 1, pwm_out[0] follows internal signal A but rises only after A has been high for db_rise consecutive cycles; a high pulse of A shorter than that produces no output pulse.
- R9: With db_en = 1, pwm_out[1] is the inverse of internal signal A, rising only after A has been low for db_fall consecutive cycles, so the two outputs are never high together.
- R10: With db_en = 0, pwm_out[0] carries internal signal A and pwm_out[1] internal signal B unchanged.
- R11: An output whose out_en bit is 0 is low, whatever its polarity bit.
- R12: An enabled output whose out_inv bit is 1 carries the inverse of its dead-band stage signal.
- R13: While fault_in is 1, every output whose fault_en bit is 1 is low in the same cycle; outputs with fault_en = 0 are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| updown_mode | input | 1 | 0: down counting, 1: up/down counting |
| sync_upd | input | 1 | 1: hold writes until the count is zero |
| load_wr | input | 1 | Write strobe for the period value |
| load_val | input | 16 | Period value to write |
| cmpa_wr | input | 1 | Write strobe for compare A |
| cmpa_val | input | 16 | Compare A value to write |
| cmpb_wr | input | 1 | Write strobe for compare B |
| cmpb_val | input | 16 | Compare B value to write |
| act_a | input | 8 | Event actions for internal signal A |
| act_b | input | 8 | Event actions for internal signal B |
| db_en | input | 1 | 1: dead-band pair from signal A, 0: bypass |
| db_rise | input | 8 | Rising-edge delay of output 0 in cycles |
| db_fall | input | 8 | Rising-edge delay of output 1 in cycles |
| out_en | input | 2 | Per-output enable |
| out_inv | input | 2 | Per-output polarity inversion |
| fault_en | input | 2 | Per-output fault forcing enable |
| fault_in | input | 1 | Fault request, forces enabled outputs low |
| cnt_out | output | 16 | Current count |
| pwm_out | output | 2 | PWM outputs |

## Verification
The bench aims at period values of 0 and 1, where zero and period events coincide and a triangle counter that misreads its turn-around would stick or overshoot, and at writes landing exactly on the zero cycle in held mode, where a wrong design would apply the value one period late or leak a mid-period write. Compare values equal to 0 or to the period test the priority order, where a design resolving in the wrong order would produce edges of the wrong polarity. Dead-band delays longer than the PWM pulse check that short pulses vanish instead of leaking a one-cycle glitch, and fault toggles check that forcing is immediate rather than one cycle late.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;

   typedef enum logic [1:0] {
      ACT_KEEP   = 2'b00,
      ACT_TOGGLE = 2'b01,
      ACT_LOW    = 2'b10,
      ACT_HIGH   = 2'b11
   } pwm_act_e;

   // event vector, most significant = highest priority
   typedef struct packed {
      logic cmpb;
      logic cmpa;
      logic at_load;
      logic at_zero;
   } pwm_evt_t;

   localparam int EVT_N       = 4;
   localparam int ACT_FIELD_W = 2 * EVT_N;
   localparam int NREG        = 3;   // period, compare A, compare B
   localparam int NOUT        = 2;

   function automatic logic apply_act(input logic cur, input logic [1:0] code);
      case (pwm_act_e'(code))
         ACT_TOGGLE: return ~cur;
         ACT_LOW:    return 1'b0;
         ACT_HIGH:   return 1'b1;
         default:    return cur;
      endcase
   endfunction

endpackage

// File: rtl/mcpwm_timebase.sv
module mcpwm_timebase
   import mcpwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        updown_mode,
   input  logic                        sync_upd,
   input  logic [NREG-1:0]             wr,
   input  logic [NREG-1:0][CNT_W-1:0]  wdata,
   output logic [CNT_W-1:0]            cnt,
   output logic [NREG-1:0][CNT_W-1:0]  act_val,
   output pwm_evt_t                    evt
);

   logic [NREG-1:0][CNT_W-1:0] act_q, pend_q, act_d;
   logic                       at_zero;
   logic                       dir_up;
   logic [CNT_W-1:0]           ld_nxt;

   assign at_zero = (cnt == '0);

   // one shadow/active pair per programmable value
   for (genvar k = 0; k < NREG; k++) begin : g_reg
      always_comb begin
         if (sync_upd) begin
            if (at_zero) act_d[k] = wr[k] ? wdata[k] : pend_q[k];
            else         act_d[k] = act_q[k];
         end else begin
            act_d[k] = wr[k] ? wdata[k] : act_q[k];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            act_q[k]  <= '0;
            pend_q[k] <= '0;
         end else begin
            act_q[k] <= act_d[k];
            if (wr[k]) pend_q[k] <= wdata[k];
         end
      end
   end

   assign ld_nxt = act_d[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         dir_up <= 1'b1;
      end else if (!updown_mode) begin
         cnt <= at_zero ? ld_nxt : cnt - 1'b1;
      end else if (dir_up) begin
         if (cnt >= ld_nxt) begin
            dir_up <= 1'b0;
            cnt    <= (ld_nxt == '0) ? '0 : ld_nxt - 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else begin
         if (at_zero) begin
            dir_up <= 1'b1;
            cnt    <= (ld_nxt == '0) ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   assign act_val      = act_q;
   assign evt.at_zero  = at_zero;
   assign evt.at_load  = (cnt == act_q[0]);
   assign evt.cmpa     = (cnt == act_q[1]);
   assign evt.cmpb     = (cnt == act_q[2]);

endmodule

// File: rtl/mcpwm_action.sv
module mcpwm_action
   import mcpwm_pkg::*;
#(
   parameter int NCH = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  pwm_evt_t                         evt,
   input  logic [NCH-1:0][ACT_FIELD_W-1:0]  act_cfg,
   output logic [NCH-1:0]                   gen
);

   logic [EVT_N-1:0] evt_vec;
   assign evt_vec = evt;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic [1:0] sel;
      logic       q;

      // highest event index with a non-keep code wins
      always_comb begin
         sel = ACT_KEEP;
         for (int e = 0; e < EVT_N; e++) begin
            if (evt_vec[e] && act_cfg[ch][2*e +: 2] != ACT_KEEP)
               sel = act_cfg[ch][2*e +: 2];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) q <= 1'b0;
         else        q <= apply_act(q, sel);
      end

      assign gen[ch] = q;
   end

endmodule

// File: rtl/mcpwm_deadband.sv
module mcpwm_deadband
   import mcpwm_pkg::*;
#(
   parameter int DLY_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               db_en,
   input  logic [DLY_W-1:0]   rise_dly,
   input  logic [DLY_W-1:0]   fall_dly,
   input  logic [NOUT-1:0]    gen,
   output logic [NOUT-1:0]    sig
);

   localparam logic [DLY_W-1:0] SAT = '1;

   // side 0 follows A, side 1 follows not A; each gets its own delay
   for (genvar i = 0; i < NOUT; i++) begin : g_side
      logic             src;
      logic [DLY_W-1:0] dly;
      logic [DLY_W-1:0] run_q;
      logic             paired;

      assign src = (i == 0) ? gen[0] : ~gen[0];
      assign dly = (i == 0) ? rise_dly : fall_dly;

      always_ff @(posedge clk) begin
         if (!rst_n)          run_q <= '0;
         else if (!src)       run_q <= '0;
         else if (run_q != SAT) run_q <= run_q + 1'b1;
      end

      assign paired = src && (run_q >= dly);
      assign sig[i] = db_en ? paired : gen[i];
   end

endmodule

// File: rtl/mcpwm_outctl.sv
module mcpwm_outctl
   import mcpwm_pkg::*;
(
   input  logic [NOUT-1:0] sig,
   input  logic [NOUT-1:0] out_en,
   input  logic [NOUT-1:0] out_inv,
   input  logic [NOUT-1:0] fault_en,
   input  logic            fault_in,
   output logic [NOUT-1:0] pwm
);

   for (genvar i = 0; i < NOUT; i++) begin : g_out
      logic forced;
      assign forced = fault_in && fault_en[i];
      assign pwm[i] = !forced && out_en[i] && (sig[i] ^ out_inv[i]);
   end

endmodule

// File: rtl/mcpwm_gen.sv
module mcpwm_gen
   import mcpwm_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             updown_mode,
   input  logic             sync_upd,
   input  logic             load_wr,
   input  logic [CNT_W-1:0] load_val,
   input  logic             cmpa_wr,
   input  logic [CNT_W-1:0] cmpa_val,
   input  logic             cmpb_wr,
   input  logic [CNT_W-1:0] cmpb_val,
   input  logic [7:0]       act_a,
   input  logic [7:0]       act_b,
   input  logic             db_en,
   input  logic [DLY_W-1:0] db_rise,
   input  logic [DLY_W-1:0] db_fall,
   input  logic [1:0]       out_en,
   input  logic [1:0]       out_inv,
   input  logic [1:0]       fault_en,
   input  logic             fault_in,
   output logic [CNT_W-1:0] cnt_out,
   output logic [1:0]       pwm_out
);

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("mcpwm_gen: CNT_W out of range");
   end
   if (DLY_W < 1 || DLY_W > 16) begin : g_bad_dly
      $error("mcpwm_gen: DLY_W out of range");
   end
   if (ACT_FIELD_W != 8 || NOUT != 2) begin : g_bad_pkg
      $error("mcpwm_gen: package widths do not match ports");
   end

   logic [NREG-1:0]            wr;
   logic [NREG-1:0][CNT_W-1:0] wdata;
   logic [NREG-1:0][CNT_W-1:0] act_val;
   logic [CNT_W-1:0]           cnt_q;
   logic [CNT_W-1:0]           ld_act;
   pwm_evt_t                   evt;
   logic [NOUT-1:0]            gen;
   logic [NOUT-1:0]            db_sig;
   logic [NOUT-1:0][ACT_FIELD_W-1:0] act_cfg;

   assign wr      = {cmpb_wr, cmpa_wr, load_wr};
   assign wdata   = {cmpb_val, cmpa_val, load_val};
   assign act_cfg = {act_b, act_a};
   assign ld_act  = act_val[0];

   mcpwm_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk         (clk),
      .rst_n       (rst_n),
      .updown_mode (updown_mode),
      .sync_upd    (sync_upd),
      .wr          (wr),
      .wdata       (wdata),
      .cnt         (cnt_q),
      .act_val     (act_val),
      .evt         (evt)
   );

   mcpwm_action #(.NCH(NOUT)) u_act (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .act_cfg (act_cfg),
      .gen     (gen)
   );

   mcpwm_deadband #(.DLY_W(DLY_W)) u_db (
      .clk      (clk),
      .rst_n    (rst_n),
      .db_en    (db_en),
      .rise_dly (db_rise),
      .fall_dly (db_fall),
      .gen      (gen),
      .sig      (db_sig)
   );

   mcpwm_outctl u_out (
      .sig      (db_sig),
      .out_en   (out_en),
      .out_inv  (out_inv),
      .fault_en (fault_en),
      .fault_in (fault_in),
      .pwm      (pwm_out)
   );

   assign cnt_out = cnt_q;

endmodule

// File: rtl/mcpwm_gen_chk.sv
module mcpwm_gen_chk #(
   parameter int CNT_W = 16,
   parameter int DLY_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             updown_mode,
   input logic             sync_upd,
   input logic             load_wr,
   input logic [7:0]       act_a,
   input logic             db_en,
   input logic [DLY_W-1:0] db_rise,
   input logic [1:0]       fault_en,
   input logic             fault_in,
   input logic [CNT_W-1:0] cnt_out,
   input logic [CNT_W-1:0] ld_act,
   input logic [1:0]       gen,
   input logic [1:0]       db_sig,
   input logic [1:0]       pwm_out
);

   p_down_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!updown_mode && cnt_out != '0) |=> (cnt_out == $past(cnt_out) - 1'b1));

   p_updown_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (updown_mode && !load_wr && cnt_out != '0 && cnt_out < ld_act)
      |=> (cnt_out == $past(cnt_out) + 1'b1 || cnt_out == $past(cnt_out) - 1'b1));

   p_sync_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_upd && cnt_out != '0) |=> $stable(ld_act));

   p_keep_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (act_a == 8'h00) |=> $stable(gen[0]));

   p_rise_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (db_en && db_rise != '0 && $rose(db_sig[0])) |-> $past(gen[0]));

   p_pair_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      db_en |-> !(db_sig[0] && db_sig[1]));

   for (genvar i = 0; i < 2; i++) begin : g_fault
      p_fault_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
         (fault_in && fault_en[i]) |-> !pwm_out[i]);
   end

endmodule

bind mcpwm_gen mcpwm_gen_chk #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .updown_mode (updown_mode),
   .sync_upd    (sync_upd),
   .load_wr     (load_wr),
   .act_a       (act_a),
   .db_en       (db_en),
   .db_rise     (db_rise),
   .fault_en    (fault_en),
   .fault_in    (fault_in),
   .cnt_out     (cnt_out),
   .ld_act      (ld_act),
   .gen         (gen),
   .db_sig      (db_sig),
   .pwm_out     (pwm_out)
);

// File: tb/mcpwm_gen_tb.sv
`timescale 1ns/1ps
module mcpwm_gen_tb;

   localparam int CW = 16;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          updown_mode, sync_upd;
   logic          load_wr, cmpa_wr, cmpb_wr;
   logic [CW-1:0] load_val, cmpa_val, cmpb_val;
   logic [7:0]    act_a, act_b;
   logic          db_en;
   logic [DW-1:0] db_rise, db_fall;
   logic [1:0]    out_en, out_inv, fault_en;
   logic          fault_in;
   logic [CW-1:0] cnt_out;
   logic [1:0]    pwm_out;

   always #4 clk = ~clk;

   mcpwm_gen #(.CNT_W(CW), .DLY_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .updown_mode(updown_mode), .sync_upd(sync_upd),
      .load_wr(load_wr), .load_val(load_val), .cmpa_wr(cmpa_wr), .cmpa_val(cmpa_val),
      .cmpb_wr(cmpb_wr), .cmpb_val(cmpb_val), .act_a(act_a), .act_b(act_b),
      .db_en(db_en), .db_rise(db_rise), .db_fall(db_fall), .out_en(out_en),
      .out_inv(out_inv), .fault_en(fault_en), .fault_in(fault_in),
      .cnt_out(cnt_out), .pwm_out(pwm_out)
   );

   int    errors = 0;
   int    checks = 0;
   bit    done = 0;
   string tag = "R1";

   // reference state
   logic [CW-1:0] m_cnt;
   logic          m_up;
   logic [CW-1:0] m_act [3];
   logic [CW-1:0] m_pend [3];
   logic          m_g [2];
   logic [DW-1:0] m_run [2];

   task automatic model_reset();
      m_cnt = '0; m_up = 1'b1;
      for (int k = 0; k < 3; k++) begin m_act[k] = '0; m_pend[k] = '0; end
      for (int i = 0; i < 2; i++) begin m_g[i] = 1'b0; m_run[i] = '0; end
   endtask

   function automatic logic [1:0] pick(logic [7:0] cfg, logic z, logic l, logic a, logic b);
      if (b && cfg[7:6] != 2'b00) return cfg[7:6];
      if (a && cfg[5:4] != 2'b00) return cfg[5:4];
      if (l && cfg[3:2] != 2'b00) return cfg[3:2];
      if (z && cfg[1:0] != 2'b00) return cfg[1:0];
      return 2'b00;
   endfunction

   function automatic logic act_on(logic cur, logic [1:0] c);
      case (c)
         2'b01:   return ~cur;
         2'b10:   return 1'b0;
         2'b11:   return 1'b1;
         default: return cur;
      endcase
   endfunction

   function automatic logic [1:0] exp_pwm();
      logic [1:0] s, o;
      if (db_en) begin
         s[0] = m_g[0] && (m_run[0] >= db_rise);
         s[1] = !m_g[0] && (m_run[1] >= db_fall);
      end else begin
         s[0] = m_g[0];
         s[1] = m_g[1];
      end
      for (int i = 0; i < 2; i++)
         o[i] = (fault_in && fault_en[i]) ? 1'b0 : (out_en[i] ? (s[i] ^ out_inv[i]) : 1'b0);
      return o;
   endfunction

   task automatic model_step();
      logic          wr [3];
      logic [CW-1:0] wv [3];
      logic [CW-1:0] nxt [3];
      logic          z, l, a, b, src;
      wr[0] = load_wr; wr[1] = cmpa_wr; wr[2] = cmpb_wr;
      wv[0] = load_val; wv[1] = cmpa_val; wv[2] = cmpb_val;
      z = (m_cnt == 0); l = (m_cnt == m_act[0]);
      a = (m_cnt == m_act[1]); b = (m_cnt == m_act[2]);
      for (int k = 0; k < 3; k++) begin
         if (sync_upd) nxt[k] = z ? (wr[k] ? wv[k] : m_pend[k]) : m_act[k];
         else          nxt[k] = wr[k] ? wv[k] : m_act[k];
      end
      for (int i = 0; i < 2; i++) begin
         src = (i == 0) ? m_g[0] : !m_g[0];
         if (!src) m_run[i] = '0;
         else if (m_run[i] != 8'hFF) m_run[i] = m_run[i] + 1'b1;
      end
      m_g[0] = act_on(m_g[0], pick(act_a, z, l, a, b));
      m_g[1] = act_on(m_g[1], pick(act_b, z, l, a, b));
      if (!updown_mode) m_cnt = z ? nxt[0] : m_cnt - 1'b1;
      else if (m_up) begin
         if (m_cnt >= nxt[0]) begin
            m_up = 1'b0; m_cnt = (nxt[0] == 0) ? '0 : nxt[0] - 1'b1;
         end else m_cnt = m_cnt + 1'b1;
      end else begin
         if (z) begin m_up = 1'b1; m_cnt = (nxt[0] == 0) ? '0 : 16'd1; end
         else m_cnt = m_cnt - 1'b1;
      end
      for (int k = 0; k < 3; k++) begin
         m_act[k] = nxt[k];
         if (wr[k]) m_pend[k] = wv[k];
      end
   endtask

   task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", t, act, exp, $time);
      end
   endtask

   // inputs are set after a falling edge; compare, advance model, cross the rising edge
   task automatic tick();
      #1;
      chk({tag, " count"}, 32'(cnt_out), 32'(m_cnt));
      chk({tag, " pwm"}, 32'(pwm_out), 32'(exp_pwm()));
      model_step();
      @(negedge clk);
      load_wr = 0; cmpa_wr = 0; cmpb_wr = 0;
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic wr_all(logic [CW-1:0] p, logic [CW-1:0] ca, logic [CW-1:0] cb);
      load_wr = 1; load_val = p; cmpa_wr = 1; cmpa_val = ca; cmpb_wr = 1; cmpb_val = cb;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(8 * 190000);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      rst_n = 0; updown_mode = 0; sync_upd = 0;
      load_wr = 0; cmpa_wr = 0; cmpb_wr = 0;
      load_val = 0; cmpa_val = 0; cmpb_val = 0;
      act_a = 0; act_b = 0; db_en = 0; db_rise = 0; db_fall = 0;
      out_en = 2'b11; out_inv = 0; fault_en = 0; fault_in = 0;
      model_reset();
      @(negedge clk);
      // R1: reset state
      tag = "R1";
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); #1;
         chk("R1 count in reset", 32'(cnt_out), 0);
         chk("R1 pwm in reset", 32'(pwm_out), 0);
      end
      @(negedge clk);
      rst_n = 1;

      // R2/R4/R6: down mode, immediate writes, A high at zero low at cmpA, B high at cmpB low at zero
      tag = "R2_R4_R6";
      act_a = 8'b00_10_00_11; act_b = 8'b11_00_00_10;
      wr_all(16'd9, 16'd4, 16'd6);
      run(40);
      wr_all(16'd5, 16'd2, 16'd3);   // R4 mid-period write
      run(30);

      // R3: up/down
      tag = "R3";
      updown_mode = 1;
      act_a = 8'b00_01_00_00;        // toggle on cmpA (twice per period)
      wr_all(16'd7, 16'd3, 16'd5);
      run(50);
      wr_all(16'd1, 16'd1, 16'd0);   // tiny period
      run(12);
      wr_all(16'd0, 16'd0, 16'd0);   // zero period
      run(8);

      // R5: held writes
      tag = "R5";
      updown_mode = 0; sync_upd = 1;
      act_a = 8'b00_10_00_11;
      wr_all(16'd10, 16'd5, 16'd8);
      run(25);
      wait_zero_minus(3);
      load_wr = 1; load_val = 16'd4;
      run(20);
      wait_zero_minus(0);
      load_wr = 1; load_val = 16'd6; cmpa_wr = 1; cmpa_val = 16'd2;  // write on the zero cycle
      run(20);
      sync_upd = 0;

      // R7: coinciding events
      tag = "R7";
      wr_all(16'd6, 16'd0, 16'd6);
      act_a = 8'b00_01_00_11;        // zero->high, cmpA(=0)->toggle wins
      act_b = 8'b10_00_11_00;        // load->high, cmpB(=load)->low wins
      run(30);
      act_a = 8'b00_00_00_11;        // cmpA code keep: zero action applies
      run(15);

      // R8/R9/R10: dead band
      tag = "R8_R9";
      act_a = 8'b00_10_00_11; act_b = 8'b11_00_00_10;
      wr_all(16'd15, 16'd7, 16'd3);
      db_en = 1; db_rise = 8'd3; db_fall = 8'd5;
      run(60);
      db_rise = 8'd10;               // longer than high time: output 0 vanishes
      run(40);
      db_rise = 0; db_fall = 0;
      run(20);
      tag = "R10";
      db_en = 0;
      run(20);

      // R11/R12/R13: output stage
      tag = "R11_R12_R13";
      db_en = 1; db_rise = 2; db_fall = 2;
      for (int i = 0; i < 60; i++) begin
         out_en = 2'($urandom); out_inv = 2'($urandom);
         fault_en = 2'($urandom); fault_in = ($urandom % 3) == 0;
         tick();
      end
      fault_in = 0;

      // random mix
      tag = "R6_random";
      for (int i = 0; i < 4000; i++) begin
         if ($urandom % 200 == 0) updown_mode = ~updown_mode;
         if ($urandom % 150 == 0) sync_upd = ~sync_upd;
         if ($urandom % 100 == 0) db_en = ~db_en;
         if ($urandom % 40 == 0) begin act_a = 8'($urandom); act_b = 8'($urandom); end
         if ($urandom % 60 == 0) begin db_rise = 8'($urandom % 6); db_fall = 8'($urandom % 6); end
         if ($urandom % 12 == 0) begin load_wr = 1; load_val = 16'($urandom % 20); end
         if ($urandom % 12 == 0) begin cmpa_wr = 1; cmpa_val = 16'($urandom % 20); end
         if ($urandom % 12 == 0) begin cmpb_wr = 1; cmpb_val = 16'($urandom % 20); end
         if ($urandom % 30 == 0) begin out_en = 2'($urandom); out_inv = 2'($urandom); fault_en = 2'($urandom); end
         fault_in = ($urandom % 10) == 0;
         tick();
      end

      finish_run();
   end

   // advance until the model count sits k cycles before reaching zero (down mode)
   task automatic wait_zero_minus(int k);
      for (int i = 0; i < 200; i++) begin
         if (m_cnt == k) return;
         tick();
      end
   endtask

endmodule